// File: doc/BRIEF.md
# Cartridge Bank Controller with Clock Register Window

This block sits between a CPU bus and the ROM and RAM of a cartridge. Writes into the read-only address space cannot change ROM contents, so the block treats them as control commands. It decodes each command by the top three address bits. It keeps the selected switchable ROM bank, the selected external RAM bank and a RAM enable flag. It then turns the CPU address into a banked ROM address and a banked RAM address.

A second function maps a small set of clock registers into the external RAM window in place of RAM. The live time counters come from outside the block. A two-step write sequence on a command region copies them into five held registers. The CPU then reads those held registers through the RAM window and can also overwrite them there. The memory arrays and the counting of time are outside this block.

Top module: `cart_bank_ctl`

## Requirements
- R1: A write to 0x0000–0x1FFF with data 0x0A sets the RAM enable flag, and one with data 0x00 clears it. Any other data value leaves the flag unchanged.
- R2: A write to 0x2000–0x3FFF selects the switchable ROM bank from data bits 6:0. A value of 0 in those bits selects bank 1.
- R3: The ROM bank presented on `rom_bank` and used in `rom_addr` is the selected bank modulo ROM_BANKS, where ROM_BANKS is a power of two (default 64).
- R4: A write to 0x4000–0x5FFF with data 0..3 selects that RAM bank and turns clock mapping off. Data 0x08..0x0C turns clock mapping on and selects clock register (data − 8). The register order is: 0 seconds, 1 minutes, 2 hours, 3 day low byte, 4 day high byte. Any other value changes nothing.
- R5: A write of 1 to 0x6000–0x7FFF while not latched copies the live counters into the held registers and sets the latched state. A write of 1 while already latched changes nothing. A write of 0 clears the latched state.
- R6: On a latch, bits 3:0 of the day high register become {000, day bit 8}. Bits 7:4 keep their previous value. The day low register takes day bits 7:0.
- R7: A read in 0xA000–0xBFFF returns the selected held clock register while clock mapping is on. Otherwise it returns `ram_rdata` if RAM is enabled, and 0xFF if RAM is disabled.
- R8: A write in 0xA000–0xBFFF while clock mapping is on updates the selected held register and keeps `ram_we` low. With mapping off, `ram_we` is high only if RAM is enabled.
- R9: For addresses 0x0000–0x3FFF, `rom_addr` uses bank 0. For 0x4000–0x7FFF it is {bank, address bits 13:0}. `ram_addr` is {RAM bank, address bits 12:0}.
- R10: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, clock mapping is off, nothing is latched and all held clock registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ram_rdata | input | 8 | Data read from the external RAM array |
| live_sec | input | 8 | Live seconds counter |
| live_min | input | 8 | Live minutes counter |
| live_hour | input | 8 | Live hours counter |
| live_day | input | 9 | Live day counter |
| rom_bank | output | ROM_BANK_W | Effective switchable ROM bank |
| ram_bank | output | RAM_BANK_W | Selected RAM bank |
| ram_enable | output | 1 | RAM enable flag |
| rtc_map | output | 1 | Clock registers shown in the RAM window |
| rtc_sel | output | 3 | Selected clock register index |
| rom_addr | output | ROM_BANK_W+14 | Banked ROM address |
| ram_addr | output | RAM_BANK_W+13 | Banked RAM address |
| ram_we | output | 1 | Write enable to the RAM array |
| win_rdata | output | 8 | Read data for the RAM window |
| lat_sec | output | 8 | Held seconds |
| lat_min | output | 8 | Held minutes |
| lat_hour | output | 8 | Held hours |
| lat_dayl | output | 8 | Held day low byte |
| lat_dayh | output | 8 | Held day high register |

## Verification
The ROM bank command is driven with in-range values and with zero. It is also driven with values whose bit 7 or bit 6 is set. These cases separate forcing the bank to 1 from wrapping modulo the bank count. The latch region gets repeated 1 writes, then a 0 followed by a 1, while the live counters change between writes. This shows whether the held registers follow the required sequence or every write. Window reads and writes are tried in each combination of mapping and enable. Day values are used with bit 8 both set and clear, over a day-high register whose upper bits were preset. This separates the nibble merge from a full-byte load.

// File: rtl/cart_bank_pkg.sv
// Package: shared constants and types of the cartridge bank controller.
// Assumes a 16-bit CPU address whose bits 15:13 pick an 8 KiB region.
package cart_bank_pkg;

    localparam int          CLK_REGS    = 5;
    localparam logic [2:0]  RGN_ENABLE  = 3'd0;
    localparam logic [2:0]  RGN_ROMSEL  = 3'd1;
    localparam logic [2:0]  RGN_RAMSEL  = 3'd2;
    localparam logic [2:0]  RGN_LATCH   = 3'd3;
    localparam logic [2:0]  RGN_WINDOW  = 3'd5;
    localparam logic [7:0]  KEY_ON      = 8'h0A;
    localparam logic [7:0]  KEY_OFF     = 8'h00;
    localparam logic [7:0]  OPEN_BUS    = 8'hFF;
    localparam logic [7:0]  CLK_SEL_LO  = 8'h08;
    localparam logic [7:0]  CLK_SEL_HI  = 8'h0C;

    // Index of each held clock register inside the window.
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DAYL = 3;
    localparam int IDX_DAYH = 4;

endpackage

// File: rtl/cbc_cmd_decode.sv
// Command decoder: turns CPU writes in the ROM space into bank, enable
// and clock-mapping state. Assumes one write per asserted cpu_wr cycle.
module cbc_cmd_decode
    import cart_bank_pkg::*;
#(
    parameter int RAM_BANKS  = 4,
    parameter int RAM_BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [2:0]            region,
    input  logic [7:0]            wdata,
    output logic [6:0]            rom_sel,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en,
    output logic                  map_on,
    output logic [2:0]            map_sel
);

    logic is_ram_val;
    logic is_clk_val;

    // Classify region-2 data as RAM bank or clock register selection.
    always_comb begin
        is_ram_val = (wdata < 8'(RAM_BANKS));
        is_clk_val = (wdata >= CLK_SEL_LO) && (wdata <= CLK_SEL_HI);
    end

    // Update the control registers from a decoded command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_sel  <= 7'd1;
            ram_bank <= '0;
            ram_en   <= 1'b0;
            map_on   <= 1'b0;
            map_sel  <= 3'd0;
        end else if (wr) begin
            case (region)
                RGN_ENABLE: begin
                    if (wdata == KEY_ON)       ram_en <= 1'b1;
                    else if (wdata == KEY_OFF) ram_en <= 1'b0;
                end
                RGN_ROMSEL: begin
                    rom_sel <= (wdata[6:0] == 7'd0) ? 7'd1 : wdata[6:0];
                end
                RGN_RAMSEL: begin
                    if (is_ram_val) begin
                        ram_bank <= wdata[RAM_BANK_W-1:0];
                        map_on   <= 1'b0;
                    end else if (is_clk_val) begin
                        map_on  <= 1'b1;
                        map_sel <= 3'(wdata - CLK_SEL_LO);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cbc_clock_latch.sv
// Held clock registers: captured from live counters by the 0-then-1
// latch sequence, or overwritten by CPU writes through the window.
// Assumes latch and window writes never coincide (distinct addresses).
module cbc_clock_latch
    import cart_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch_wr,
    input  logic [7:0]            latch_data,
    input  logic [7:0]            live_sec,
    input  logic [7:0]            live_min,
    input  logic [7:0]            live_hour,
    input  logic [8:0]            live_day,
    input  logic                  poke,
    input  logic [2:0]            poke_sel,
    input  logic [7:0]            poke_data,
    output logic [CLK_REGS*8-1:0] held_bus
);

    logic       held;
    logic       fire;
    logic [7:0] cur  [CLK_REGS];
    logic [7:0] load [CLK_REGS];

    // A latch fires on a 1 written while nothing is held.
    always_comb fire = latch_wr && (latch_data == 8'd1) && !held;

    // Track whether a capture is held until a 0 is written.
    always_ff @(posedge clk) begin
        if (!rst_n)                               held <= 1'b0;
        else if (fire)                            held <= 1'b1;
        else if (latch_wr && latch_data == 8'd0)  held <= 1'b0;
    end

    // Form the capture value of every held register.
    always_comb begin
        load[IDX_SEC]  = live_sec;
        load[IDX_MIN]  = live_min;
        load[IDX_HOUR] = live_hour;
        load[IDX_DAYL] = live_day[7:0];
        load[IDX_DAYH] = {cur[IDX_DAYH][7:4], 3'b000, live_day[8]};
    end

    for (genvar i = 0; i < CLK_REGS; i++) begin : g_reg
        // One held register: capture, CPU overwrite, or hold.
        always_ff @(posedge clk) begin
            if (!rst_n)                          cur[i] <= 8'd0;
            else if (fire)                       cur[i] <= load[i];
            else if (poke && poke_sel == 3'(i))  cur[i] <= poke_data;
        end
        assign held_bus[i*8 +: 8] = cur[i];
    end

endmodule

// File: rtl/cbc_addr_map.sv
// Address mapper: banked ROM/RAM addresses, RAM write gating and the
// RAM window read mux. Purely combinational. Assumes ROM_BANKS is a
// power of two between 2 and 128.
module cbc_addr_map
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS  = 64,
    parameter int RAM_BANK_W = 2,
    localparam int ROM_BANK_W = $clog2(ROM_BANKS)
) (
    input  logic [15:0]              cpu_addr,
    input  logic                     cpu_wr,
    input  logic [6:0]               rom_sel,
    input  logic [RAM_BANK_W-1:0]    ram_bank,
    input  logic                     ram_en,
    input  logic                     map_on,
    input  logic [2:0]               map_sel,
    input  logic [CLK_REGS*8-1:0]    held_bus,
    input  logic [7:0]               ram_rdata,
    output logic [ROM_BANK_W-1:0]    rom_bank,
    output logic [ROM_BANK_W+13:0]   rom_addr,
    output logic [RAM_BANK_W+12:0]   ram_addr,
    output logic                     ram_we,
    output logic                     poke,
    output logic [7:0]               win_rdata
);

    logic       in_win;
    logic [7:0] clk_val;

    // Wrap the selected bank onto the available banks.
    always_comb rom_bank = rom_sel[ROM_BANK_W-1:0];

    // Fixed bank 0 below 0x4000, switchable bank above.
    always_comb begin
        if (cpu_addr[14]) rom_addr = {rom_bank, cpu_addr[13:0]};
        else              rom_addr = {{ROM_BANK_W{1'b0}}, cpu_addr[13:0]};
        ram_addr = {ram_bank, cpu_addr[12:0]};
    end

    // Pick the held clock register named by the mapping index.
    always_comb begin
        if (int'(map_sel) < CLK_REGS) clk_val = held_bus[map_sel*8 +: 8];
        else                          clk_val = OPEN_BUS;
    end

    // Window decode, write gating and read priority.
    always_comb begin
        in_win = (cpu_addr[15:13] == RGN_WINDOW);
        ram_we = cpu_wr && in_win && ram_en && !map_on;
        poke   = cpu_wr && in_win && map_on;
        if (!in_win)     win_rdata = OPEN_BUS;
        else if (map_on) win_rdata = clk_val;
        else if (ram_en) win_rdata = ram_rdata;
        else             win_rdata = OPEN_BUS;
    end

endmodule

// File: rtl/cart_bank_ctl.sv
// Top of the cartridge bank controller. Wires the command decoder, the
// held clock registers and the address mapper. Assumes the memory arrays
// and the live time counters are outside.
module cart_bank_ctl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4,
    localparam int ROM_BANK_W = $clog2(ROM_BANKS),
    localparam int RAM_BANK_W = $clog2(RAM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            cpu_addr,
    input  logic [7:0]             cpu_wdata,
    input  logic                   cpu_wr,
    input  logic [7:0]             ram_rdata,
    input  logic [7:0]             live_sec,
    input  logic [7:0]             live_min,
    input  logic [7:0]             live_hour,
    input  logic [8:0]             live_day,
    output logic [ROM_BANK_W-1:0]  rom_bank,
    output logic [RAM_BANK_W-1:0]  ram_bank,
    output logic                   ram_enable,
    output logic                   rtc_map,
    output logic [2:0]             rtc_sel,
    output logic [ROM_BANK_W+13:0] rom_addr,
    output logic [RAM_BANK_W+12:0] ram_addr,
    output logic                   ram_we,
    output logic [7:0]             win_rdata,
    output logic [7:0]             lat_sec,
    output logic [7:0]             lat_min,
    output logic [7:0]             lat_hour,
    output logic [7:0]             lat_dayl,
    output logic [7:0]             lat_dayh
);

    logic [6:0]            rom_sel;
    logic [CLK_REGS*8-1:0] held_bus;
    logic                  poke;
    logic                  latch_wr;

    // Latch commands are writes into the fourth command region.
    always_comb latch_wr = cpu_wr && (cpu_addr[15:13] == RGN_LATCH);

    cbc_cmd_decode #(
        .RAM_BANKS  (RAM_BANKS),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cpu_wr),
        .region   (cpu_addr[15:13]),
        .wdata    (cpu_wdata),
        .rom_sel  (rom_sel),
        .ram_bank (ram_bank),
        .ram_en   (ram_enable),
        .map_on   (rtc_map),
        .map_sel  (rtc_sel)
    );

    cbc_clock_latch u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_wr   (latch_wr),
        .latch_data (cpu_wdata),
        .live_sec   (live_sec),
        .live_min   (live_min),
        .live_hour  (live_hour),
        .live_day   (live_day),
        .poke       (poke),
        .poke_sel   (rtc_sel),
        .poke_data  (cpu_wdata),
        .held_bus   (held_bus)
    );

    cbc_addr_map #(
        .ROM_BANKS  (ROM_BANKS),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_map (
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .rom_sel   (rom_sel),
        .ram_bank  (ram_bank),
        .ram_en    (ram_enable),
        .map_on    (rtc_map),
        .map_sel   (rtc_sel),
        .held_bus  (held_bus),
        .ram_rdata (ram_rdata),
        .rom_bank  (rom_bank),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .poke      (poke),
        .win_rdata (win_rdata)
    );

    // Unpack the held registers onto named ports.
    always_comb begin
        lat_sec  = held_bus[IDX_SEC*8  +: 8];
        lat_min  = held_bus[IDX_MIN*8  +: 8];
        lat_hour = held_bus[IDX_HOUR*8 +: 8];
        lat_dayl = held_bus[IDX_DAYL*8 +: 8];
        lat_dayh = held_bus[IDX_DAYH*8 +: 8];
    end

endmodule

// File: rtl/cart_bank_ctl_chk.sv
// Checker for the cartridge bank controller, bound to the top module.
// Observes ports only.
module cart_bank_ctl_chk #(
    parameter int ROM_BANK_W = 6,
    parameter int RAM_BANK_W = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [15:0]            cpu_addr,
    input logic [7:0]             cpu_wdata,
    input logic                   cpu_wr,
    input logic [ROM_BANK_W-1:0]  rom_bank,
    input logic                   ram_enable,
    input logic                   rtc_map,
    input logic [2:0]             rtc_sel,
    input logic [ROM_BANK_W+13:0] rom_addr,
    input logic                   ram_we,
    input logic [7:0]             lat_sec,
    input logic [7:0]             lat_dayh
);

    // R1: the enable key turns RAM on in the next cycle.
    a_r1_enable_key: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h0A |=> ram_enable);

    // R1: data other than the two keys leaves the flag alone.
    a_r1_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata != 8'h0A && cpu_wdata != 8'h00
        |=> $stable(ram_enable));

    // R2: a zero bank field selects bank 1.
    a_r2_zero_forced: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr[15:13] == 3'd1 && cpu_wdata[6:0] == 7'd0
        |=> rom_bank == ROM_BANK_W'(1));

    // R4: a clock selection maps register (data - 8).
    a_r4_map_select: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr[15:13] == 3'd2 && cpu_wdata >= 8'h08 && cpu_wdata <= 8'h0C
        |=> rtc_map && rtc_sel == 3'($past(cpu_wdata) - 8'h08));

    // R5: without a write the held seconds do not change.
    a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(lat_sec));

    // R6: latch commands never touch the day high upper nibble.
    a_r6_dayh_upper: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr[15:13] == 3'd3 |=> lat_dayh[7:4] == $past(lat_dayh[7:4]));

    // R8: the RAM array is never written while clock registers are mapped.
    a_r8_no_ram_write_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_map |-> !ram_we);

    // R9: the fixed window always addresses bank 0.
    a_r9_fixed_window: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:14] == 2'b00 |-> rom_addr[ROM_BANK_W+13:14] == '0);

endmodule

bind cart_bank_ctl cart_bank_ctl_chk #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_wr     (cpu_wr),
    .rom_bank   (rom_bank),
    .ram_enable (ram_enable),
    .rtc_map    (rtc_map),
    .rtc_sel    (rtc_sel),
    .rom_addr   (rom_addr),
    .ram_we     (ram_we),
    .lat_sec    (lat_sec),
    .lat_dayh   (lat_dayh)
);

// File: tb/cart_bank_ctl_tb.sv
// Directed bench for the cartridge bank controller.
module cart_bank_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  ram_rdata = 8'h5A;
    logic [7:0]  live_sec = 8'h00;
    logic [7:0]  live_min = 8'h00;
    logic [7:0]  live_hour = 8'h00;
    logic [8:0]  live_day = 9'h000;
    logic [5:0]  rom_bank;
    logic [1:0]  ram_bank;
    logic        ram_enable;
    logic        rtc_map;
    logic [2:0]  rtc_sel;
    logic [19:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_we;
    logic [7:0]  win_rdata;
    logic [7:0]  lat_sec, lat_min, lat_hour, lat_dayl, lat_dayh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cart_bank_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ram_rdata(ram_rdata), .live_sec(live_sec),
        .live_min(live_min), .live_hour(live_hour), .live_day(live_day),
        .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_enable(ram_enable),
        .rtc_map(rtc_map), .rtc_sel(rtc_sel), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .ram_we(ram_we), .win_rdata(win_rdata),
        .lat_sec(lat_sec), .lat_min(lat_min), .lat_hour(lat_hour),
        .lat_dayl(lat_dayl), .lat_dayh(lat_dayh)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One CPU write; returns ram_we as seen during the write cycle.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, output logic we_seen);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1 we_seen = ram_we;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        logic w;
        cpu_write(a, d, w);
    endtask

    task automatic t_reset();
        cpu_addr = 16'hA000; #1;
        check("R10 rom_bank", rom_bank, 1);
        check("R10 ram_bank", ram_bank, 0);
        check("R10 ram_enable", ram_enable, 0);
        check("R10 rtc_map", rtc_map, 0);
        check("R10 held", {lat_sec, lat_min, lat_hour, lat_dayl}, 0);
        check("R10 dayh", lat_dayh, 0);
        check("R10 window closed", win_rdata, 8'hFF);
    endtask

    task automatic t_enable();
        wr(16'h0000, 8'h0A);  check("R1 enable", ram_enable, 1);
        wr(16'h1FFF, 8'h0B);  check("R1 other value ignored", ram_enable, 1);
        wr(16'h1234, 8'h00);  check("R1 disable", ram_enable, 0);
        wr(16'h0000, 8'h8A);  check("R1 near key ignored", ram_enable, 0);
    endtask

    task automatic t_rom_bank();
        wr(16'h2000, 8'h05);  check("R2 bank 5", rom_bank, 5);
        wr(16'h3FFF, 8'h00);  check("R2 zero forced to 1", rom_bank, 1);
        wr(16'h2000, 8'h80);  check("R2 bit7 ignored zero forced", rom_bank, 1);
        wr(16'h2000, 8'h3F);  check("R2 bank 63", rom_bank, 63);
    endtask

    task automatic t_wrap();
        wr(16'h2000, 8'h45);  check("R3 wrap 0x45", rom_bank, 5);
        wr(16'h2000, 8'h40);  check("R3 wrap 0x40 to 0", rom_bank, 0);
    endtask

    task automatic t_addr_map();
        wr(16'h2000, 8'h05);
        wr(16'h4000, 8'h02);
        cpu_addr = 16'h4123; #1; check("R9 switchable addr", rom_addr, 20'h14123);
        cpu_addr = 16'h3ABC; #1; check("R9 fixed addr", rom_addr, 20'h03ABC);
        cpu_addr = 16'hA456; #1; check("R9 ram addr", ram_addr, 15'h4456);
        wr(16'h2000, 8'h3F);
        wr(16'h4000, 8'h03);
        cpu_addr = 16'h7FFF; #1; check("R9 top rom addr", rom_addr, 20'hFFFFF);
        cpu_addr = 16'hBFFF; #1; check("R9 top ram addr", ram_addr, 15'h7FFF);
    endtask

    task automatic t_ram_sel();
        wr(16'h4000, 8'h01);  check("R4 ram bank 1", ram_bank, 1);
        wr(16'h5FFF, 8'h0A);  check("R4 map on", rtc_map, 1);
        check("R4 sel 2", rtc_sel, 2);
        wr(16'h4000, 8'h05);  check("R4 value 5 ignored map", rtc_map, 1);
        check("R4 value 5 ignored bank", ram_bank, 1);
        wr(16'h4000, 8'h0D);  check("R4 value 0x0D ignored sel", rtc_sel, 2);
        wr(16'h4000, 8'h03);  check("R4 ram bank 3", ram_bank, 3);
        check("R4 map off", rtc_map, 0);
    endtask

    task automatic t_latch();
        live_sec = 8'h12; live_min = 8'h34; live_hour = 8'h05; live_day = 9'h1A7;
        wr(16'h6000, 8'h01);
        check("R5 latch sec", lat_sec, 8'h12);
        check("R5 latch min", lat_min, 8'h34);
        check("R5 latch hour", lat_hour, 8'h05);
        check("R6 day low", lat_dayl, 8'hA7);
        check("R6 day high", lat_dayh, 8'h01);
        live_sec = 8'h20;
        wr(16'h7FFF, 8'h01);  check("R5 second 1 ignored", lat_sec, 8'h12);
        wr(16'h6000, 8'h00);  check("R5 zero keeps values", lat_sec, 8'h12);
        wr(16'h6000, 8'h01);  check("R5 relatch", lat_sec, 8'h20);
    endtask

    task automatic t_window();
        logic w;
        wr(16'h0000, 8'h00);
        wr(16'h4000, 8'h08);
        cpu_write(16'hA010, 8'h3C, w);
        check("R8 mapped write no ram_we", w, 0);
        check("R8 mapped write updates sec", lat_sec, 8'h3C);
        cpu_addr = 16'hA000; #1; check("R7 mapped read", win_rdata, 8'h3C);
        wr(16'h4000, 8'h0C);
        cpu_write(16'hB000, 8'hC0, w);
        check("R8 poke day high", lat_dayh, 8'hC0);
        check("R8 other regs untouched", lat_sec, 8'h3C);
        live_day = 9'h100;
        wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
        check("R6 upper kept bit8 set", lat_dayh, 8'hC1);
        live_day = 9'h0FF;
        wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
        check("R6 upper kept bit8 clear", lat_dayh, 8'hC0);
        wr(16'h0000, 8'h0A);
        cpu_write(16'hA000, 8'h77, w);
        check("R8 mapped enabled no ram_we", w, 0);
        wr(16'h4000, 8'h00);
        cpu_addr = 16'hA000; #1; check("R7 ram read", win_rdata, 8'h5A);
        cpu_write(16'hA000, 8'h11, w);
        check("R8 enabled ram_we", w, 1);
        wr(16'h0000, 8'h00);
        cpu_addr = 16'hA000; #1; check("R7 disabled read", win_rdata, 8'hFF);
        cpu_write(16'hA000, 8'h11, w);
        check("R8 disabled no ram_we", w, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_rom_bank();
        t_wrap();
        t_addr_map();
        t_ram_sel();
        t_latch();
        t_window();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule